// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. A sixteen-state machine, clocked on the rising edge of the test clock, walks through its states according to the mode-select input. It routes a serial data input through either an 8-bit instruction register or one of three data registers toward a serial data output. The data registers are a 1-bit pass-through stage, a 32-bit identification word and a 21-bit test-control register.

The serial output changes only on falling test-clock edges. A separate output-enable marks when the serial output is valid, so a pad driver can tri-state the line outside the shift states. The current state is visible as a 4-bit code. A run flag marks the idle state, in which an external test operation picked by the control register may run. Reset is synchronous, active high and sampled on the rising test-clock edge.

Top module: `scan_port_ctrl`

## Requirements
- R1: The state advances only on the rising edge of `tck`, using the sampled `tms`. It is output on `state` with this encoding: 0 reset, 1 idle, 2 DR-select, 3 DR-capture, 4 DR-shift, 5 DR-exit1, 6 DR-pause, 7 DR-exit2, 8 DR-update, 9 IR-select, 10 IR-capture, 11 IR-shift, 12 IR-exit1, 13 IR-pause, 14 IR-exit2, 15 IR-update. The transitions follow the standard boundary-scan state graph.
- R2: `rst` high at a rising edge puts the state at 0. From any state, five rising edges with `tms` high reach state 0.
- R3: While in state 0, the instruction register is loaded with 8'b10000001. This opcode selects the identification register, whose DR scan returns `IDCODE_VAL` (default 32'h4C17A0F3) LSB first.
- R4: While in state 0, the control register is loaded with 21'b000000000000000000010.
- R5: Leaving IR-capture loads 8'b00000001 into the instruction shift stage. IR-shift moves `tdi` in at bit 7 and out at bit 0. The instruction takes the shifted value on the edge that leaves IR-update.
- R6: Opcode 8'h82 selects the 21-bit control register. Opcode 8'hFF, and every opcode other than 8'h81 and 8'h82, selects the 1-bit pass-through register. That register captures 0, so a DR scan returns the input delayed by one bit.
- R7: The selected data register captures on the edge that leaves DR-capture and shifts LSB first during DR-shift. The control register takes the shifted value on the edge that leaves DR-update.
- R8: `tdo_oe` goes high on the first falling `tck` edge after DR-shift or IR-shift is entered, and `tdo` then shows the shift stage's LSB. Both return low on the falling edge after the shift state is left.
- R9: `run_active` is high exactly while the state is idle.
- R10: The select states last one cycle. Pausing a shift through exit1, pause and exit2 keeps the shift contents, and shifting resumes at the next bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| state | output | 4 | Current controller state code |
| run_active | output | 1 | High while in the idle state |

## Verification
The hardest situation to reach from the ports is a shift that is paused in the middle and then resumed, because the bit count must continue across the pause. The bench scans the control register, leaves DR-shift partway through the word, waits in pause, comes back through exit2, and then compares the read-back word and the next scan against the expected values. Long random walks on `tms` reach every state. Each walk ends with five high `tms` cycles, which shows that the reset state is reached and that the instruction and control registers hold their reset values again.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [3:0] {
    ST_RESET    = 4'd0,
    ST_IDLE     = 4'd1,
    ST_DR_SEL   = 4'd2,
    ST_DR_CAP   = 4'd3,
    ST_DR_SHIFT = 4'd4,
    ST_DR_EXIT1 = 4'd5,
    ST_DR_PAUSE = 4'd6,
    ST_DR_EXIT2 = 4'd7,
    ST_DR_UPD   = 4'd8,
    ST_IR_SEL   = 4'd9,
    ST_IR_CAP   = 4'd10,
    ST_IR_SHIFT = 4'd11,
    ST_IR_EXIT1 = 4'd12,
    ST_IR_PAUSE = 4'd13,
    ST_IR_EXIT2 = 4'd14,
    ST_IR_UPD   = 4'd15
  } tap_st_t;

  typedef enum logic [1:0] {
    SEL_BYP = 2'd0,
    SEL_ID  = 2'd1,
    SEL_CTL = 2'd2
  } dr_sel_t;
endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_pkg::*;
(
  input  logic    tck,
  input  logic    rst,
  input  logic    tms,
  output tap_st_t st,
  output logic    run_active
);
  tap_st_t nxt;

  always_comb begin
    unique case (st)
      ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nxt = tms ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   nxt = tms ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_SHIFT: nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_EXIT1: nxt = tms ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: nxt = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
      ST_DR_EXIT2: nxt = tms ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   nxt = tms ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_SHIFT: nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_EXIT1: nxt = tms ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: nxt = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
      ST_IR_EXIT2: nxt = tms ? ST_IR_UPD   : ST_IR_SHIFT;
      ST_IR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
      default:     nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      st         <= ST_RESET;
      run_active <= 1'b0;
    end else begin
      st         <= nxt;
      run_active <= (nxt == ST_IDLE);
    end
  end
endmodule

// File: rtl/scan_shreg.sv
module scan_shreg #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         cap,
  input  logic         shf,
  input  logic [W-1:0] cap_val,
  input  logic         tdi,
  output logic [W-1:0] q
);
  generate
    if (W == 1) begin : g_single
      always_ff @(posedge tck) begin
        if (cap)      q <= cap_val;
        else if (shf) q <= tdi;
      end
    end else begin : g_multi
      always_ff @(posedge tck) begin
        if (cap)      q <= cap_val;
        else if (shf) q <= {tdi, q[W-1:1]};
      end
    end
  endgenerate
endmodule

// File: rtl/scan_ir.sv
module scan_ir
  import scan_pkg::*;
#(
  parameter int              IR_W       = 8,
  parameter logic [IR_W-1:0] IR_RESET   = 8'b1000_0001,
  parameter logic [IR_W-1:0] IR_CAPTURE = 8'b0000_0001
) (
  input  logic            tck,
  input  logic            rst,
  input  tap_st_t         st,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            sh_lsb
);
  logic [IR_W-1:0] sh;

  scan_shreg #(.W(IR_W)) u_sh (
    .tck     (tck),
    .cap     (st == ST_IR_CAP),
    .shf     (st == ST_IR_SHIFT),
    .cap_val (IR_CAPTURE),
    .tdi     (tdi),
    .q       (sh)
  );

  always_ff @(posedge tck) begin
    if (rst || st == ST_RESET) ir_q <= IR_RESET;
    else if (st == ST_IR_UPD)  ir_q <= sh;
  end

  assign sh_lsb = sh[0];
endmodule

// File: rtl/scan_dr.sv
module scan_dr
  import scan_pkg::*;
#(
  parameter int               IR_W       = 8,
  parameter int               ID_W       = 32,
  parameter int               CTL_W      = 21,
  parameter logic [ID_W-1:0]  IDCODE_VAL = 32'h4C17_A0F3,
  parameter logic [CTL_W-1:0] CTL_RESET  = 21'd2,
  parameter logic [IR_W-1:0]  OP_ID      = 8'h81,
  parameter logic [IR_W-1:0]  OP_CTL     = 8'h82
) (
  input  logic             tck,
  input  logic             rst,
  input  tap_st_t          st,
  input  logic [IR_W-1:0]  ir_q,
  input  logic             tdi,
  output logic [CTL_W-1:0] ctl_q,
  output logic             sh_lsb
);
  dr_sel_t          sel;
  logic             cap_en, shf_en;
  logic [0:0]       byp_sh;
  logic [ID_W-1:0]  id_sh;
  logic [CTL_W-1:0] ctl_sh;

  always_comb begin
    if (ir_q == OP_ID)       sel = SEL_ID;
    else if (ir_q == OP_CTL) sel = SEL_CTL;
    else                     sel = SEL_BYP;
  end

  assign cap_en = (st == ST_DR_CAP);
  assign shf_en = (st == ST_DR_SHIFT);

  scan_shreg #(.W(1)) u_byp (
    .tck(tck), .cap(cap_en && sel == SEL_BYP), .shf(shf_en && sel == SEL_BYP),
    .cap_val(1'b0), .tdi(tdi), .q(byp_sh)
  );

  scan_shreg #(.W(ID_W)) u_id (
    .tck(tck), .cap(cap_en && sel == SEL_ID), .shf(shf_en && sel == SEL_ID),
    .cap_val(IDCODE_VAL), .tdi(tdi), .q(id_sh)
  );

  scan_shreg #(.W(CTL_W)) u_ctl (
    .tck(tck), .cap(cap_en && sel == SEL_CTL), .shf(shf_en && sel == SEL_CTL),
    .cap_val(ctl_q), .tdi(tdi), .q(ctl_sh)
  );

  always_ff @(posedge tck) begin
    if (rst || st == ST_RESET)                  ctl_q <= CTL_RESET;
    else if (st == ST_DR_UPD && sel == SEL_CTL) ctl_q <= ctl_sh;
  end

  always_comb begin
    unique case (sel)
      SEL_ID:  sh_lsb = id_sh[0];
      SEL_CTL: sh_lsb = ctl_sh[0];
      default: sh_lsb = byp_sh[0];
    endcase
  end
endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
  import scan_pkg::*;
#(
  parameter int               IR_W       = 8,
  parameter int               ID_W       = 32,
  parameter int               CTL_W      = 21,
  parameter logic [ID_W-1:0]  IDCODE_VAL = 32'h4C17_A0F3,
  parameter logic [CTL_W-1:0] CTL_RESET  = 21'd2,
  parameter logic [IR_W-1:0]  OP_ID      = 8'h81,
  parameter logic [IR_W-1:0]  OP_CTL     = 8'h82,
  parameter logic [IR_W-1:0]  IR_CAPTURE = 8'h01
) (
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  input  logic       tdi,
  output logic       tdo,
  output logic       tdo_oe,
  output logic [3:0] state,
  output logic       run_active
);
  tap_st_t          st;
  logic [IR_W-1:0]  ir_q;
  logic [CTL_W-1:0] ctl_q;
  logic             ir_lsb, dr_lsb;

  scan_fsm u_fsm (
    .tck(tck), .rst(rst), .tms(tms), .st(st), .run_active(run_active)
  );

  scan_ir #(.IR_W(IR_W), .IR_RESET(OP_ID), .IR_CAPTURE(IR_CAPTURE)) u_ir (
    .tck(tck), .rst(rst), .st(st), .tdi(tdi), .ir_q(ir_q), .sh_lsb(ir_lsb)
  );

  scan_dr #(
    .IR_W(IR_W), .ID_W(ID_W), .CTL_W(CTL_W), .IDCODE_VAL(IDCODE_VAL),
    .CTL_RESET(CTL_RESET), .OP_ID(OP_ID), .OP_CTL(OP_CTL)
  ) u_dr (
    .tck(tck), .rst(rst), .st(st), .ir_q(ir_q), .tdi(tdi),
    .ctl_q(ctl_q), .sh_lsb(dr_lsb)
  );

  // serial output launched half a cycle after the shift edge
  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (st == ST_DR_SHIFT) || (st == ST_IR_SHIFT);
      if (st == ST_IR_SHIFT)      tdo <= ir_lsb;
      else if (st == ST_DR_SHIFT) tdo <= dr_lsb;
      else                        tdo <= 1'b0;
    end
  end

  assign state = st;
endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_pkg::*;
#(
  parameter int               IR_W      = 8,
  parameter int               CTL_W     = 21,
  parameter logic [IR_W-1:0]  IR_RESET  = 8'h81,
  parameter logic [CTL_W-1:0] CTL_RESET = 21'd2
) (
  input logic             tck,
  input logic             rst,
  input logic             tms,
  input logic [3:0]       state,
  input logic             tdo_oe,
  input logic             run_active,
  input logic [IR_W-1:0]  ir_q,
  input logic [CTL_W-1:0] ctl_q
);
  AST_SELECT_ONE_CYCLE: assert property (@(posedge tck) disable iff (rst)
    (state == ST_DR_SEL) |=> (state == ST_DR_CAP || state == ST_IR_SEL)); // R10
  AST_IDLE_FROM_RESET: assert property (@(posedge tck) disable iff (rst)
    (state == ST_RESET && !tms) |=> (state == ST_IDLE)); // R1
  AST_RESET_ENTRY: assert property (@(posedge tck)
    rst |=> (state == ST_RESET)); // R2
  AST_IR_RESET_VAL: assert property (@(posedge tck) disable iff (rst)
    (state == ST_RESET) |=> (ir_q == IR_RESET)); // R3
  AST_CTL_RESET_VAL: assert property (@(posedge tck) disable iff (rst)
    (state == ST_RESET) |=> (ctl_q == CTL_RESET)); // R4
  AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (rst)
    tdo_oe == (state == ST_DR_SHIFT || state == ST_IR_SHIFT)); // R8
  AST_RUN_IN_IDLE: assert property (@(posedge tck) disable iff (rst)
    run_active == (state == ST_IDLE)); // R9
endmodule

bind scan_port_ctrl scan_port_chk #(
  .IR_W(IR_W), .CTL_W(CTL_W), .IR_RESET(OP_ID), .CTL_RESET(CTL_RESET)
) u_chk (
  .tck(tck), .rst(rst), .tms(tms), .state(state), .tdo_oe(tdo_oe),
  .run_active(run_active), .ir_q(ir_q), .ctl_q(ctl_q)
);

// File: tb/test_scan_port_ctrl.sv
module test_scan_port_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID_VAL = 32'h4C17_A0F3;

  logic tck = 1'b0, rst = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe, run_active;
  logic [3:0] state;
  int n_run = 0, n_fail = 0, model = 0;
  bit finished = 0;

  scan_port_ctrl i_scan_port_ctrl (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_oe(tdo_oe), .state(state), .run_active(run_active)
  );

  always #(CLK_PERIOD/2) tck = ~tck;

  function automatic int nxt(input int s, input bit m);
    case (s)
      0: return m ? 0 : 1;     1: return m ? 2 : 1;
      2: return m ? 9 : 3;     3: return m ? 5 : 4;
      4: return m ? 5 : 4;     5: return m ? 8 : 6;
      6: return m ? 7 : 6;     7: return m ? 8 : 4;
      8: return m ? 2 : 1;     9: return m ? 0 : 10;
      10: return m ? 12 : 11;  11: return m ? 12 : 11;
      12: return m ? 15 : 13;  13: return m ? 14 : 13;
      14: return m ? 15 : 11;  default: return m ? 2 : 1;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one rising edge, then sample after the following falling edge
  task automatic step(input bit m, input bit d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
    model = nxt(model, m);
    check(state == model[3:0], "R1 state", {28'd0, state}, model);
    check(run_active == (model == 1), "R9 run flag", {31'd0, run_active}, {31'd0, model == 1});
    check(tdo_oe == (model == 4 || model == 11), "R8 output enable", {31'd0, tdo_oe},
          {31'd0, model == 4 || model == 11});
  endtask

  task automatic to_idle();
    repeat (5) step(1, 0);
    check(state == 4'd0, "R2 five high tms", {28'd0, state}, 0);
    step(0, 0);
  endtask

  task automatic ir_scan(input logic [7:0] val, output logic [7:0] out);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 8; i++) begin
      out[i] = tdo;
      step(i == 7, val[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic dr_scan(input int n, input logic [31:0] val, input int pause_at, output logic [31:0] out);
    out = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      out[i] = tdo;
      if (i == pause_at && i != n - 1) begin
        step(1, val[i]); step(0, 0); step(0, 0); step(0, 0); step(1, 0); step(0, 0);
      end else begin
        step(i == n - 1, val[i]);
      end
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    repeat (400000) @(posedge tck);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] ir_o;
    logic [31:0] d_o, v, exp;
    void'($urandom(32'd1234));
    repeat (3) @(posedge tck);
    @(negedge tck); rst = 1'b0; #1;
    model = 0;
    check(state == 4'd0 && !tdo_oe && !run_active, "R2 reset state",
          {28'd0, state}, 0);

    to_idle();
    ir_scan(8'h81, ir_o);
    check(ir_o == 8'h01, "R5 IR capture", {24'd0, ir_o}, 32'h01);
    dr_scan(32, 32'hFFFF_FFFF, -1, d_o);
    check(d_o == ID_VAL, "R3 identification", d_o, ID_VAL);

    ir_scan(8'h82, ir_o);
    dr_scan(21, 32'h0, -1, d_o);
    check(d_o == 32'd2, "R4 control reset", d_o, 2);
    for (int k = 0; k < 6; k++) begin
      v = {11'd0, 21'($urandom)};
      dr_scan(21, v, (k == 0) ? -1 : int'($urandom_range(0, 19)), d_o);
      dr_scan(21, v, -1, d_o);
      check(d_o == v, "R7 R10 control write and read", d_o, v);
    end

    for (int k = 0; k < 6; k++) begin
      logic [7:0] op;
      op = (k == 0) ? 8'hFF : 8'($urandom);
      if (op == 8'h81 || op == 8'h82) op = 8'h3C;
      ir_scan(op, ir_o);
      v = $urandom;
      dr_scan(12, v, -1, d_o);
      exp = {20'd0, v[10:0], 1'b0};
      check(d_o == exp, "R6 pass-through", d_o, exp);
    end

    ir_scan(8'h82, ir_o);
    for (int k = 0; k < 20; k++) begin
      dr_scan(21, 32'h0015_5A5A, -1, d_o);
      for (int j = 0; j < 150; j++) step(1'($urandom), 1'($urandom));
      to_idle();
      dr_scan(32, $urandom, (k % 2 == 0) ? 9 : -1, d_o);
      check(d_o == ID_VAL, "R3 IR back to reset value", d_o, ID_VAL);
      ir_scan(8'h82, ir_o);
      dr_scan(21, 32'h0, -1, d_o);
      check(d_o == 32'd2, "R4 control back to reset value", d_o, 2);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule